// File: doc/BRIEF.md
# Flash memory command sequencer

This block fronts a small byte-wide non-volatile array model and lets a host run program, erase and blank-check operations on it. A command is only accepted when it arrives as three bus writes in a fixed order: a write into the array window (which captures the target address and data), a write of the command code, then a launch write to the status register. A mis-ordered or aborted sequence raises an access error. While the error is raised, no further command can be built until the host clears the error.

Operation time is measured in ticks of a slow flash clock. The flash clock is the bus clock divided by a programmable divider value plus one. Each operation finishes after a fixed number of those ticks. Erasure returns bytes to 0xFF, and programming can only clear bits. The sequencer has a one-deep command buffer ahead of the execution stage. This lets a burst of program commands queue its next byte while the current byte is still being written.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, buf_empty=1, cmd_done=1, acc_err=0, blank_fail=0, and every array byte reads 0xFF.
- R2: The sequence is an array write (wr_sel=0), then a command write (wr_sel=2) of 0x20 (byte program) or 0x25 (burst program), then a status write (wr_sel=3) with wr_data[7]=1. It stores the old byte AND the written data at the written address.
- R3: A command write whose code is not one of 0x05, 0x20, 0x25, 0x40 or 0x41 sets acc_err and discards the sequence.
- R4: A status write with wr_data[7]=0 after the array write and before the launch aborts the sequence and sets acc_err. The aborted command never touches the array.
- R5: While acc_err=1, array, command and launch writes have no effect. A status write with wr_data[5]=1 clears acc_err.
- R6: An array write before the first divider write (wr_sel=1) sets acc_err.
- R7: Each of the following sets acc_err and discards the partial sequence: a command write without a preceding array write, a second array write, or a launch with no command latched.
- R8: Page erase (0x40) sets to 0xFF every byte whose address bits above bit 8 match the written address. Other pages are left unchanged. Mass erase (0x41) sets every byte to 0xFF. The data value is ignored for both, and the address value is ignored for mass erase.
- R9: With divider value D, cmd_done falls on the launch write and rises N*(D+1)+1 clock cycles after the clock edge that samples that write. N is 9 for byte program, 4 for burst program, 4000 for page erase, 20000 for mass erase and 16 for blank check.
- R10: Blank check (0x05) clears blank_fail at its start. At its end it sets blank_fail to 1 if any byte is not 0xFF, and leaves it at 0 otherwise.
- R11: A launch made while an operation runs holds buf_empty=0 and cmd_done=0 until that operation ends. The queued command then runs, and buf_empty returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register/array write strobe |
| wr_sel | input | 2 | Write target: 0 array, 1 divider, 2 command, 3 status |
| wr_addr | input | 10 | Array byte address for array writes |
| wr_data | input | 8 | Write data; status bit 7 launch/abort, bit 5 clear error |
| rd_addr | input | 10 | Array read address |
| rd_data | output | 8 | Array byte at rd_addr |
| buf_empty | output | 1 | Command buffer can accept a launch |
| cmd_done | output | 1 | No command running or queued |
| acc_err | output | 1 | Access error flag |
| blank_fail | output | 1 | Last blank check found a programmed byte |

## Verification
The assertions assume that the host drives wr_en only as a single-cycle strobe. They also assume that wr_sel and wr_data are meaningful only while wr_en is high, and that the divider is never written while an operation runs. The stimulus drives every write for exactly one clock, from the falling edge. It changes the divider only while cmd_done is high. It waits for completion before reading the array back, except in the burst case, where it deliberately queues a second launch during a running program.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int ADDR_W  = 10,
  parameter int PAGE_W  = 9,
  parameter int DIV_W   = 6,
  parameter int T_BYTE  = 9,
  parameter int T_BURST = 4,
  parameter int T_PAGE  = 4000,
  parameter int T_MASS  = 20000,
  parameter int T_BLANK = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              buf_empty,
  output logic              cmd_done,
  output logic              acc_err,
  output logic              blank_fail
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(T_MASS + 1);
  localparam logic [7:0] C_BLANK = 8'h05, C_PROG = 8'h20, C_BURST = 8'h25,
                         C_PAGE = 8'h40, C_MASS = 8'h41;

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_CMD, S_QUEUED} seq_t;
  seq_t seq;

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] b_addr, e_addr;
  logic [7:0]        b_data, b_cmd, e_data, e_cmd;
  logic [DIV_W-1:0]  div_q, tcnt;
  logic [CNT_W-1:0]  rem;
  logic              div_ok, busy, seq_err, all_ff;

  wire w_arr  = wr_en && wr_sel == 2'd0;
  wire w_div  = wr_en && wr_sel == 2'd1;
  wire w_cmd  = wr_en && wr_sel == 2'd2;
  wire w_stat = wr_en && wr_sel == 2'd3;
  wire code_ok = wr_data inside {C_BLANK, C_PROG, C_BURST, C_PAGE, C_MASS};
  wire start = seq == S_QUEUED && !busy;
  wire tick  = busy && tcnt == div_q;
  wire fin   = tick && rem == CNT_W'(1);

  assign rd_data   = mem[rd_addr];
  assign buf_empty = seq != S_QUEUED;
  assign cmd_done  = !busy && seq != S_QUEUED;

  always_comb begin
    seq_err = 1'b0;
    if (!acc_err) begin
      if (w_arr && (!div_ok || seq != S_IDLE)) seq_err = 1'b1;
      if (w_cmd && (seq != S_DATA || !code_ok)) seq_err = 1'b1;
      if (w_stat && wr_data[7] && seq != S_CMD) seq_err = 1'b1;
    end
    if (w_stat && !wr_data[7] && (seq == S_DATA || seq == S_CMD)) seq_err = 1'b1;
  end

  always_comb begin
    all_ff = 1'b1;
    for (int i = 0; i < DEPTH; i++)
      if (mem[i] != 8'hFF) all_ff = 1'b0;
  end

  function automatic logic [CNT_W-1:0] dur(input logic [7:0] c);
    case (c)
      C_PROG:  return CNT_W'(T_BYTE);
      C_BURST: return CNT_W'(T_BURST);
      C_PAGE:  return CNT_W'(T_PAGE);
      C_MASS:  return CNT_W'(T_MASS);
      default: return CNT_W'(T_BLANK);
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq <= S_IDLE; acc_err <= 1'b0; div_q <= '0; div_ok <= 1'b0;
      b_addr <= '0; b_data <= '0; b_cmd <= '0;
    end else begin
      if (w_div) begin
        div_q  <= wr_data[DIV_W-1:0];
        div_ok <= 1'b1;
      end
      if (start) seq <= S_IDLE;
      if (seq_err) begin
        acc_err <= 1'b1;
        if (seq != S_QUEUED) seq <= S_IDLE;
      end else begin
        if (w_stat && wr_data[5]) acc_err <= 1'b0;
        if (!acc_err) begin
          if (w_arr) begin
            seq <= S_DATA; b_addr <= wr_addr; b_data <= wr_data;
          end
          if (w_cmd) begin
            seq <= S_CMD; b_cmd <= wr_data;
          end
          if (w_stat && wr_data[7]) seq <= S_QUEUED;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; tcnt <= '0; rem <= '0; blank_fail <= 1'b0;
      e_addr <= '0; e_data <= '0; e_cmd <= '0;
    end else if (start) begin
      busy <= 1'b1; tcnt <= '0; rem <= dur(b_cmd);
      e_addr <= b_addr; e_data <= b_data; e_cmd <= b_cmd;
      if (b_cmd == C_BLANK) blank_fail <= 1'b0;
    end else if (busy) begin
      tcnt <= tick ? '0 : tcnt + 1'b1;
      if (tick) rem <= rem - 1'b1;
      if (fin) begin
        busy <= 1'b0;
        if (e_cmd == C_BLANK) blank_fail <= !all_ff;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (fin) begin
      case (e_cmd)
        C_PROG, C_BURST: mem[e_addr] <= mem[e_addr] & e_data;
        C_PAGE:
          for (int i = 0; i < DEPTH; i++)
            if ((ADDR_W'(i) >> PAGE_W) == (e_addr >> PAGE_W)) mem[i] <= 8'hFF;
        C_MASS:
          for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        default: ;
      endcase
    end
  end

  a_r3_bad_code_err: assert property (@(posedge clk) disable iff (!rst_n)
    (w_cmd && !acc_err && seq == S_DATA && !code_ok) |=> (acc_err && seq == S_IDLE));
  a_r4_abort_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
    (w_stat && !wr_data[7] && (seq == S_DATA || seq == S_CMD)) |=> (acc_err && seq == S_IDLE));
  a_r5_err_blocks_seq: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_err && seq == S_IDLE && (w_arr || w_cmd)) |=> seq == S_IDLE);
  a_r6_no_run_undivided: assert property (@(posedge clk) disable iff (!rst_n)
    !div_ok |-> !busy);
  a_r9_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_done) |-> $past(busy));
  a_r11_start_from_queue: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(seq == S_QUEUED));
endmodule

// File: tb/sim_flash_cmd_seq.sv
`timescale 1ns/10ps
module sim_flash_cmd_seq;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [9:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic buf_empty, cmd_done, acc_err, blank_fail;
  int n_chk = 0, n_bad = 0, cyc;
  bit mon_busy = 0, finished = 0;

  typedef struct { string req; int kind; int arg; int exp; } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  flash_cmd_seq u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .buf_empty(buf_empty), .cmd_done(cmd_done), .acc_err(acc_err), .blank_fail(blank_fail));

  initial forever begin
    item_t it;
    int act;
    wait (q.size() > 0);
    mon_busy = 1;
    it = q.pop_front();
    case (it.kind)
      0: begin rd_addr = 10'(it.arg); #0.1; act = int'(rd_data); end
      1: act = int'({buf_empty, cmd_done, acc_err, blank_fail});
      default: act = it.arg;
    endcase
    n_chk++;
    if (act != it.exp) begin
      n_bad++;
      $display("FAIL %s kind %0d: actual 0x%0h expected 0x%0h", it.req, it.kind, act, it.exp);
    end
    mon_busy = 0;
  end

  task automatic drain();
    wait (q.size() == 0 && !mon_busy);
  endtask
  task automatic exp_byte(string r, int a, int v);
    q.push_back('{r, 0, a, v}); drain();
  endtask
  task automatic exp_flags(string r, int v);
    q.push_back('{r, 1, 0, v}); drain();
  endtask
  task automatic exp_val(string r, int o, int v);
    q.push_back('{r, 2, o, v}); drain();
  endtask

  task automatic wr(input logic [1:0] s, input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_addr = 10'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int a, input logic [7:0] d, input logic [7:0] c, output int n);
    wr(2'd0, a, d);
    wr(2'd2, 0, c);
    wr(2'd3, 0, 8'h80);
    exp_val("R9 done low after launch", int'(cmd_done), 0);
    n = 0;
    while (n < 30000) begin
      @(posedge clk); #1; n++;
      if (cmd_done) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    exp_flags("R1 reset flags", 4'b1100);
    exp_byte("R1 reset byte", 0, 8'hFF);
    exp_byte("R1 reset byte", 1023, 8'hFF);

    wr(2'd0, 4, 8'h00);
    exp_flags("R6 no divider", 4'b1110);
    wr(2'd3, 0, 8'h20);
    exp_flags("R5 clear", 4'b1100);

    wr(2'd1, 0, 8'd2);
    run(5, 8'hA5, 8'h20, cyc);
    exp_val("R9 byte program time", cyc, 9 * 3 + 1);
    exp_byte("R2 program", 5, 8'hA5);
    exp_flags("R2 flags", 4'b1100);
    run(5, 8'h0F, 8'h20, cyc);
    exp_byte("R2 and-program", 5, 8'h05);

    wr(2'd0, 6, 8'h00); wr(2'd2, 0, 8'h21);
    exp_flags("R3 bad code", 4'b1110);
    wr(2'd0, 6, 8'h00); wr(2'd2, 0, 8'h20); wr(2'd3, 0, 8'h80);
    repeat (40) @(negedge clk);
    exp_flags("R5 blocked", 4'b1110);
    exp_byte("R5 untouched", 6, 8'hFF);
    wr(2'd3, 0, 8'h20);
    exp_flags("R5 cleared", 4'b1100);

    wr(2'd0, 7, 8'h00); wr(2'd2, 0, 8'h20); wr(2'd3, 0, 8'h00);
    exp_flags("R4 abort after command", 4'b1110);
    wr(2'd3, 0, 8'h20);
    wr(2'd0, 7, 8'h00); wr(2'd3, 0, 8'h00);
    exp_flags("R4 abort after array write", 4'b1110);
    wr(2'd3, 0, 8'h20);
    repeat (40) @(negedge clk);
    exp_byte("R4 aborted byte", 7, 8'hFF);

    wr(2'd2, 0, 8'h20);
    exp_flags("R7 command first", 4'b1110);
    wr(2'd3, 0, 8'h20);
    wr(2'd0, 8, 8'h00); wr(2'd0, 9, 8'h00);
    exp_flags("R7 double array write", 4'b1110);
    wr(2'd3, 0, 8'h20);
    wr(2'd0, 8, 8'h00); wr(2'd3, 0, 8'h80);
    exp_flags("R7 launch no command", 4'b1110);
    wr(2'd3, 0, 8'h20);
    run(8, 8'h3C, 8'h20, cyc);
    exp_byte("R7 recovered program", 8, 8'h3C);

    wr(2'd1, 0, 8'd0);
    run(0, 8'h00, 8'h05, cyc);
    exp_val("R9 blank check time", cyc, 17);
    exp_flags("R10 blank fail", 4'b1101);

    run(600, 8'h00, 8'h20, cyc);
    exp_val("R9 byte program div0", cyc, 10);
    exp_byte("R2 page1 program", 600, 8'h00);
    run(1000, 8'h12, 8'h40, cyc);
    exp_val("R9 page erase time", cyc, 4001);
    exp_byte("R8 page erased", 600, 8'hFF);
    exp_byte("R8 page erased", 512, 8'hFF);
    exp_byte("R8 other page kept", 5, 8'h05);
    exp_byte("R8 other page kept", 8, 8'h3C);

    wr(2'd1, 0, 8'd3);
    wr(2'd0, 10, 8'h11); wr(2'd2, 0, 8'h25); wr(2'd3, 0, 8'h80);
    wr(2'd0, 11, 8'h22); wr(2'd2, 0, 8'h25); wr(2'd3, 0, 8'h80);
    exp_flags("R11 queued launch", 4'b0001);
    for (int k = 0; k < 200 && !cmd_done; k++) @(negedge clk);
    exp_flags("R11 queue drained", 4'b1101);
    exp_byte("R11 first burst byte", 10, 8'h11);
    exp_byte("R11 queued burst byte", 11, 8'h22);

    wr(2'd1, 0, 8'd0);
    run(3, 8'h00, 8'h41, cyc);
    exp_val("R9 mass erase time", cyc, 20001);
    exp_byte("R8 mass erased", 5, 8'hFF);
    exp_byte("R8 mass erased", 8, 8'hFF);
    exp_byte("R8 mass erased", 11, 8'hFF);
    run(0, 8'h00, 8'h05, cyc);
    exp_flags("R10 blank pass", 4'b1100);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule